// File: doc/BRIEF.md
# Transmit Input Phase-Absorbing FIFO

This block takes the parallel transmit word of one serial channel and hands it to the internal word-rate clock domain. Each word carries 8 data bits, a flag asking for a control character, and a start-of-frame flag. The words can be captured on a per-channel external write clock or on the reference-derived read clock, chosen by a mode input. The external clock runs at the same frequency as the read clock, but its phase is unknown.

A small FIFO with Gray-coded pointers connects the two domains. Right after reset, the read side waits until the FIFO holds about half its depth, then reads one word on every read-clock cycle. From then on, slow phase wander between the clocks moves the fill level up and down around the centre without losing any words. If the write side overruns the read side, or the read side catches up with the write side, a sticky error flag rises. While that flag is set, the output word is held at zero.

Top module: `txin_phase_fifo`

## Requirements
- R1: Each output word carries the same 8 data bits, control flag and start-of-frame flag that were presented together on the input.
- R2: With `useRefWr` = 1, input words are captured on rising edges of `rdClk`. With `useRefWr` = 0, they are captured on rising edges of `extWrClk`.
- R3: While `rstN` is low, `outValid`, `errFlag`, `outData`, `outCtrl` and `outSof` are all 0.
- R4: After `rstN` rises, `outValid` goes high within 16 read-clock cycles. The first word delivered is one of the first 6 words presented after the release.
- R5: Once `outValid` is high, it stays high on every read-clock cycle for as long as `errFlag` is low. Each high cycle delivers one new word.
- R6: The two clocks may have any fixed phase offset plus up to ±3 ns of drift. Under those conditions, words leave in exactly the order they were written, with no gaps or repeats, and `errFlag` stays low.
- R7: `errFlag` is set in two cases: when the write clock runs persistently faster than the read clock (overflow), and when it runs persistently slower (underflow).
- R8: Once set, `errFlag` stays set until `rstN` is driven low. A reset clears it.
- R9: From the second read-clock cycle after `errFlag` rises, `outData`, `outCtrl`, `outSof` and `outValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rdClk | input | 1 | Reference-derived word-rate clock. Drives the read side and, in reference mode, the write side as well |
| extWrClk | input | 1 | Per-channel external write clock, frequency-locked to `rdClk` |
| rstN | input | 1 | Asynchronous active-low reset. It is synchronized into each domain and starts the alignment |
| useRefWr | input | 1 | Write clock select: 1 selects `rdClk`, 0 selects `extWrClk` |
| inData | input | 8 | User data byte of the input word |
| inCtrl | input | 1 | Control-character request flag of the input word |
| inSof | input | 1 | Start-of-frame flag of the input word |
| outData | output | 8 | Data byte in the read domain |
| outCtrl | output | 1 | Control flag in the read domain |
| outSof | output | 1 | Start-of-frame flag in the read domain |
| outValid | output | 1 | High on each read cycle that delivers a word |
| errFlag | output | 1 | Sticky overflow/underflow indication |

## Verification
The assertions assume three things about the inputs. `rstN` is held low for several read-clock cycles. `useRefWr` changes only while `rstN` is low. A new input word is presented on every write-clock cycle, so the flow on both sides is continuous and the error properties hold. The stimulus meets these conditions: `useRefWr` and the phase offset of the external clock are changed only inside a reset pulse, and a data word is driven on every falling edge of the selected write clock. Phase wander is applied as small random steps whose running sum stays within ±3 ns. The overflow and underflow runs deliberately use a different clock period and are checked with monitoring of the data sequence switched off.

// File: rtl/txin_pkg.sv
package txin_pkg;

  // One parallel transmit word as it travels through the FIFO.
  typedef struct packed {
    logic [7:0] data;
    logic       ctrl;
    logic       sof;
  } txWord_t;

  // Strobes from the pointer control to the storage datapath.
  typedef struct packed {
    logic wrEn;   // write-domain capture enable
    logic rdEn;   // read-domain advance
    logic blank;  // force the output word to zero
  } fifoStrobe_t;

endpackage

// File: rtl/txin_sync.sv
module txin_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/txin_fifo_ctrl.sv
module txin_fifo_ctrl
  import txin_pkg::*;
#(
  parameter  int DEPTH       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int AIW         = $clog2(DEPTH)
) (
  input  logic           wrClk,
  input  logic           rdClk,
  input  logic           rstN,
  output fifoStrobe_t    strb,
  output logic [AIW-1:0] wrAddr,
  output logic [AIW-1:0] rdAddr,
  output logic           rdRstN,
  output logic           outValid,
  output logic           errFlag
);

  localparam int AW = AIW + 1;
  localparam logic [AW-1:0] ONE_V   = AW'(1);
  localparam logic [AW-1:0] DEPTH_V = AW'(DEPTH);
  localparam logic [AW-1:0] LAG_V   = AW'(SYNC_STAGES);
  localparam logic [AW-1:0] START_V = AW'(DEPTH / 2 - SYNC_STAGES);
  localparam logic [AW-1:0] OVF_V   = AW'(DEPTH + SYNC_STAGES);

  function automatic logic [AW-1:0] toGray(input logic [AW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW-1:0] fromGray(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Reset release, one synchronizer per domain.
  logic wrRstN;
  txin_sync #(.W(1), .STAGES(SYNC_STAGES)) wrRstSync_i (
    .clk(wrClk), .rstN(rstN), .d(1'b1), .q(wrRstN));
  txin_sync #(.W(1), .STAGES(SYNC_STAGES)) rdRstSync_i (
    .clk(rdClk), .rstN(rstN), .d(1'b1), .q(rdRstN));

  // Write domain: free-running pointer, overflow watch.
  logic [AW-1:0] wrPtr, wrGray, rdGraySync, rdSyncBin, wrLead;
  logic          ovfW;

  assign rdSyncBin = fromGray(rdGraySync);
  // The read pointer seen here is at least SYNC_STAGES words stale.
  assign wrLead    = wrPtr - rdSyncBin;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtr  <= '0;
      wrGray <= '0;
      ovfW   <= 1'b0;
    end else begin
      wrPtr  <= wrPtr + ONE_V;
      wrGray <= toGray(wrPtr + ONE_V);
      if (wrLead >= OVF_V) ovfW <= 1'b1;
    end
  end

  txin_sync #(.W(AW), .STAGES(SYNC_STAGES)) rdPtrSync_i (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGraySync));

  // Read domain: centring start, advance, underflow watch.
  logic [AW-1:0] rdPtr, rdGray, wrGraySync, wrSyncBin, fill, rdLead;
  logic          started, errQ, validQ, ovfSync, underflow, rdGo;

  txin_sync #(.W(AW), .STAGES(SYNC_STAGES)) wrPtrSync_i (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync));
  txin_sync #(.W(1), .STAGES(SYNC_STAGES)) ovfSync_i (
    .clk(rdClk), .rstN(rdRstN), .d(ovfW), .q(ovfSync));

  assign wrSyncBin = fromGray(wrGraySync);
  assign fill      = wrSyncBin - rdPtr;
  assign rdLead    = rdPtr - wrSyncBin;
  assign underflow = started && (rdLead >= LAG_V) && (rdLead < DEPTH_V);
  assign rdGo      = started && !errQ;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr   <= '0;
      rdGray  <= '0;
      started <= 1'b0;
      errQ    <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      if (!started && fill >= START_V && fill < DEPTH_V) started <= 1'b1;
      if (rdGo) begin
        rdPtr  <= rdPtr + ONE_V;
        rdGray <= toGray(rdPtr + ONE_V);
      end
      validQ <= rdGo;
      if (underflow || ovfSync) errQ <= 1'b1;
    end
  end

  assign strb.wrEn  = wrRstN;
  assign strb.rdEn  = rdGo;
  assign strb.blank = errQ;
  assign wrAddr     = wrPtr[AIW-1:0];
  assign rdAddr     = rdPtr[AIW-1:0];
  assign outValid   = validQ;
  assign errFlag    = errQ;

endmodule

// File: rtl/txin_fifo_dp.sv
module txin_fifo_dp
  import txin_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int AIW   = $clog2(DEPTH)
) (
  input  logic           wrClk,
  input  logic           rdClk,
  input  logic           rdRstN,
  input  fifoStrobe_t    strb,
  input  logic [AIW-1:0] wrAddr,
  input  logic [AIW-1:0] rdAddr,
  input  txWord_t        wrWord,
  output txWord_t        rdWord
);

  txWord_t mem [DEPTH];
  txWord_t outQ;

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) mem[wrAddr] <= wrWord;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         outQ <= '0;
    else if (strb.blank) outQ <= '0;
    else if (strb.rdEn)  outQ <= mem[rdAddr];
  end

  assign rdWord = outQ;

endmodule

// File: rtl/txin_phase_fifo.sv
module txin_phase_fifo
  import txin_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rdClk,
  input  logic       extWrClk,
  input  logic       rstN,
  input  logic       useRefWr,
  input  logic [7:0] inData,
  input  logic       inCtrl,
  input  logic       inSof,
  output logic [7:0] outData,
  output logic       outCtrl,
  output logic       outSof,
  output logic       outValid,
  output logic       errFlag
);

  localparam int AIW = $clog2(DEPTH);

  // Write clock select; changed only while reset is held.
  logic wrClk;
  assign wrClk = useRefWr ? rdClk : extWrClk;

  fifoStrobe_t    strb;
  logic [AIW-1:0] wrAddr, rdAddr;
  logic           rdRstN;
  txWord_t        wrWord, rdWord;

  assign wrWord = '{data: inData, ctrl: inCtrl, sof: inSof};

  txin_fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .rdRstN(rdRstN),
    .outValid(outValid), .errFlag(errFlag));

  txin_fifo_dp #(.DEPTH(DEPTH)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .rdRstN(rdRstN), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrWord(wrWord), .rdWord(rdWord));

  assign outData = rdWord.data;
  assign outCtrl = rdWord.ctrl;
  assign outSof  = rdWord.sof;

endmodule

// File: rtl/txin_phase_fifo_chk.sv
module txin_phase_fifo_chk (
  input logic       rdClk,
  input logic       rstN,
  input logic       outValid,
  input logic       errFlag,
  input logic [7:0] outData,
  input logic       outCtrl,
  input logic       outSof
);

  // R3: everything quiet while reset is held.
  always @(posedge rdClk) begin
    if (!rstN) begin
      p_reset_quiet_r3: assert (!outValid && !errFlag && outData == 8'd0 && !outCtrl && !outSof)
        else $error("reset state not quiet");
    end
  end

  // R5: a running stream stops only through the error flag.
  p_valid_steady_r5: assert property (@(posedge rdClk) disable iff (!rstN)
    outValid |=> (outValid || errFlag));

  // R8: the error flag is sticky.
  p_err_sticky_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9: output word blanked once the error has been seen for a cycle.
  p_blank_on_err_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    (errFlag && $past(errFlag)) |-> (outData == 8'd0 && !outCtrl && !outSof && !outValid));

  // R4: the stream starts only from a clean state.
  p_clean_start_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(outValid) |-> (!errFlag && !$past(errFlag)));

endmodule

bind txin_phase_fifo txin_phase_fifo_chk chk_i (.*);

// File: tb/txin_phase_fifo_tb_top.sv
`timescale 1ns/1ps
module txin_phase_fifo_tb_top;

  logic       rdClk = 1'b0, extClk = 1'b0, rstN = 1'b0, useRef = 1'b0;
  logic [7:0] inData = 8'd0;
  logic       inCtrl = 1'b0, inSof = 1'b0;
  logic [7:0] outData;
  logic       outCtrl, outSof, outValid, errFlag;
  logic       wrClkTb;

  int          checks = 0, fails = 0;
  real         halfNs = 10.0, shiftReq = 0.0, wanderSum = 0.0, step = 0.0;
  bit          wanderOn = 1'b0, monOn = 1'b0, locked = 1'b0;
  int unsigned wrIdx = 0, expIdx = 0, releaseIdx = 0, cyc = 0, sinceRel = 0, wanderCnt = 0;
  logic [1:0]  hist [256];
  logic [1:0]  flags;
  logic [7:0]  lowDiff;

  txin_phase_fifo dut_i (
    .rdClk(rdClk), .extWrClk(extClk), .rstN(rstN), .useRefWr(useRef),
    .inData(inData), .inCtrl(inCtrl), .inSof(inSof),
    .outData(outData), .outCtrl(outCtrl), .outSof(outSof),
    .outValid(outValid), .errFlag(errFlag));

  // 50 MHz read clock
  always #10 rdClk = ~rdClk;

  // External write clock: same period, shiftable phase
  initial forever begin
    #(halfNs + shiftReq) extClk = 1'b1;
    shiftReq = 0.0;
    #(halfNs) extClk = 1'b0;
  end

  assign wrClkTb = useRef ? rdClk : extClk;

  function automatic logic [7:0] wordByte(input int unsigned i);
    return 8'(i * 29);
  endfunction

  function automatic logic [7:0] idxOfByte(input logic [7:0] b);
    return 8'(b * 53);  // 53 is the inverse of 29 mod 256
  endfunction

  function automatic void chk(input bit ok, input string req, input string what,
                              input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Writer: one new word per write-clock cycle, driven on the falling edge
  always @(negedge wrClkTb) begin
    flags = 2'($urandom_range(0, 3));
    hist[wrIdx[7:0]] = flags;
    inData = wordByte(wrIdx);
    {inCtrl, inSof} = flags;
    wrIdx = wrIdx + 1;
  end

  // Bounded random phase wander, running sum kept within +-3 ns
  always @(posedge rdClk) begin
    if (wanderOn) begin
      wanderCnt++;
      if (wanderCnt % 24 == 0) begin
        step = ($urandom_range(0, 1) != 0) ? 0.25 : -0.25;
        if (wanderSum + step <= 3.0 && wanderSum + step >= -3.0) begin
          wanderSum = wanderSum + step;
          shiftReq  = step;
        end
      end
    end
  end

  // Read-side monitor and watchdog
  always @(negedge rdClk) begin
    cyc++;
    sinceRel++;
    if (cyc > 150000) begin
      chk(1'b0, "WATCHDOG", "run did not finish", cyc, 150000);
      finishRun();
    end
    if (monOn && rstN) begin
      if (outValid) begin
        if (!locked) begin
          lowDiff = idxOfByte(outData) - releaseIdx[7:0];
          chk(lowDiff <= 8'd6, "R4", "first word index after release", lowDiff, 6);
          chk(sinceRel <= 16, "R4", "cycles until first valid", sinceRel, 16);
          expIdx = releaseIdx + lowDiff;
          locked = 1'b1;
        end else begin
          chk(outData == wordByte(expIdx), "R6", "data byte in sequence", outData, wordByte(expIdx));
        end
        chk({outCtrl, outSof} == hist[expIdx[7:0]], "R1", "ctrl/sof flags", {outCtrl, outSof},
            hist[expIdx[7:0]]);
        expIdx = expIdx + 1;
      end else if (locked && !errFlag) begin
        chk(1'b0, "R5", "gap in output stream", 0, 1);
      end
      if (errFlag) chk(1'b0, "R6", "error flag in clean run", 1, 0);
    end
  end

  task automatic doReset(input bit refMode, input real offsetNs);
    rstN = 1'b0; monOn = 1'b0; locked = 1'b0; wanderOn = 1'b0;
    halfNs = 10.0; useRef = refMode;
    shiftReq = offsetNs;
    repeat (6) @(negedge rdClk);
    #1;
    chk(!outValid, "R3", "outValid in reset", outValid, 0);
    chk(!errFlag, "R3", "errFlag in reset", errFlag, 0);
    chk({outData, outCtrl, outSof} == 10'd0, "R3", "output word in reset",
        {outData, outCtrl, outSof}, 0);
    @(negedge rdClk);
    releaseIdx = wrIdx;
    rstN = 1'b1;
    sinceRel = 0;
    monOn = 1'b1;
  endtask

  task automatic cleanRun(input int n, input string req);
    repeat (n) @(negedge rdClk);
    #1;
    chk(locked, req, "stream locked", locked, 1);
    chk(!errFlag, req, "errFlag low after run", errFlag, 0);
  endtask

  initial begin
    void'($urandom(32'd7051));

    // Aligned phase, directed extreme drift of +3 ns then -3 ns
    doReset(1'b0, 0.0);
    cleanRun(100, "R6");
    shiftReq = 3.0;
    cleanRun(100, "R6");
    shiftReq = -6.0;
    cleanRun(100, "R6");

    // Several fixed phase offsets with random bounded wander
    foreach (hist[i]) if (i < 3) begin
      doReset(1'b0, (i == 0) ? 7.0 : (i == 1) ? 13.5 : real'($urandom_range(1, 19)));
      wanderSum = 0.0;
      wanderOn = 1'b1;
      cleanRun(300, "R6");
    end

    // Reference mode: write side captures on the read clock
    doReset(1'b1, 0.0);
    cleanRun(200, "R2");

    // Overflow: write clock persistently faster
    doReset(1'b0, 4.0);
    cleanRun(60, "R6");
    monOn = 1'b0;
    halfNs = 8.0;
    repeat (120) @(negedge rdClk);
    halfNs = 10.0;
    #1;
    chk(errFlag, "R7", "errFlag after overflow", errFlag, 1);
    repeat (3) @(negedge rdClk);
    #1;
    chk(!outValid, "R9", "outValid during error", outValid, 0);
    chk({outData, outCtrl, outSof} == 10'd0, "R9", "output word during error",
        {outData, outCtrl, outSof}, 0);
    repeat (60) @(negedge rdClk);
    #1;
    chk(errFlag, "R8", "errFlag still set", errFlag, 1);

    // Reset clears the sticky flag (R8), then clean again
    doReset(1'b0, 0.0);
    cleanRun(100, "R8");

    // Underflow: write clock persistently slower
    monOn = 1'b0;
    halfNs = 12.5;
    repeat (120) @(negedge rdClk);
    halfNs = 10.0;
    #1;
    chk(errFlag, "R7", "errFlag after underflow", errFlag, 1);
    repeat (3) @(negedge rdClk);
    #1;
    chk({outData, outCtrl, outSof, outValid} == 11'd0, "R9", "blanked after underflow",
        {outData, outCtrl, outSof, outValid}, 0);

    finishRun();
  end

endmodule